// File: doc/BRIEF.md
# Host Port Slave Bridge

This block is the device end of a narrow host port. An external host reaches the device's 32-bit memory space over a 16-bit bus. The bus has a two-bit register select, a read/write line, a halfword-identifier line, an active-low strobe and a ready output. Three registers sit behind the port: a one-bit control register, a 32-bit address register and a 32-bit data latch. Every 32-bit quantity crosses the bus as two halfword strobes. The control register decides which half travels first.

On the device side, the block issues single 32-bit reads and writes through a request/acknowledge port. Writes are staged in the latch and go out after the second halfword arrives. Reads fetch a whole word on the first halfword and serve the second halfword from the latch. With the auto-increment select, the address steps forward by one word after each complete access, and the next word is fetched ahead of time.

The host's select, direction, halfword and strobe lines are synchronised to the internal clock. An access is taken on the synchronised falling edge of the strobe. The ready output reads high (not ready) while a memory transaction is in flight. A strobe that arrives during that time is dropped and recorded as a protocol error.

Top module: `hpb_bridge`

## Requirements
- R1: After reset, the not-ready output, the memory request, the protocol error flag and the data output enable are all 0, and the halfword-order bit is 0.
- R2: The select encodes the target: 00 control register, 01 address register, 10 data with address post-increment, 11 data with fixed address. The halfword input is 0 for the first halfword of a pair and 1 for the second. Address halfwords are written and read back individually.
- R3: When the order bit is 1, the first halfword is bits 15:0 and the second is bits 31:16. When it is 0, the first halfword is bits 31:16. This applies to address and data accesses.
- R4: A control write of either halfword sets the order bit from data bit 0. A control read returns the order bit in bit 0, with zeros elsewhere, for either halfword.
- R5: A data write issues one memory write, carrying the address register and the assembled word, only after the second halfword. The first halfword issues no memory request.
- R6: The not-ready output is 1 while a memory request is outstanding. The request, its address and its direction hold steady until the acknowledge.
- R7: A first-halfword data read fetches the word at the address register and drives the selected half once ready. A second-halfword read is served from the latched word without a memory request.
- R8: After the second halfword of a select-10 data access, the address advances by 4 and the word there is fetched in advance. The next first-halfword read is then served without a memory request. Select 11 leaves the address unchanged.
- R9: The data output enable is 1 exactly while the synchronised strobe is low and the synchronised read/write line is 1.
- R10: A strobe taken while not ready has no effect on any register, and sets a protocol error flag that only reset clears.
- R11: Writing any address halfword, or any data halfword, discards a word fetched in advance, so the next first-halfword read fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsel_i | input | 2 | Host register select |
| hrw_i | input | 1 | Host direction, 1 = read |
| hhalf_i | input | 1 | Host halfword identifier, 0 = first |
| hstrb_ni | input | 1 | Host strobe, active low |
| hdata_i | input | 16 | Host data into the block |
| hdata_o | output | 16 | Host data out of the block |
| hdata_oe_o | output | 1 | Output enable for the host data bus |
| hnrdy_o | output | 1 | Not-ready, 1 while a memory transaction is in flight |
| proto_err_o | output | 1 | Sticky flag for a strobe taken while not ready |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request direction, 1 = write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write word |
| mem_ack_i | input | 1 | Single-cycle memory acknowledge |
| mem_rdata_i | input | 32 | Memory read word, valid with acknowledge |

## Verification
A wrong order bit or a wrong lane choice swaps halves. That shows in the next memory write word, or in the next halfword read back, one access later. A stuck or wrongly set prefetch flag shows as an acknowledge count that is one higher or lower than expected on the very next first-halfword read. A bad address step shows in the next memory address and in the address read back. A mishandled busy strobe shows at once on the sticky error flag, and on the control register read that follows.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_ADDR = 2'b01,
    SEL_DINC = 2'b10,
    SEL_DFIX = 2'b11
  } hsel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_PF
  } st_e;
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hpb_engine.sv
module hpb_engine
  import hpb_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  hsel_e             sel_i,
  input  logic              rw_i,
  input  logic              half_i,
  input  logic [WORD_W/2-1:0] wdata_i,
  output logic [WORD_W/2-1:0] rdata_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int HALF_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  st_e               st_q;
  logic              order_q, pf_q, inc_q, rd_hi_q, err_q;
  logic              req_q, we_q;
  logic [WORD_W-1:0] addr_q, latch_q, maddr_q, mwd_q;
  logic [HALF_W-1:0] hout_q;
  logic              hi_lane;

  function automatic logic [WORD_W-1:0] put_half(logic [WORD_W-1:0] w, logic hi,
                                                 logic [HALF_W-1:0] h);
    return hi ? {h, w[HALF_W-1:0]} : {w[WORD_W-1:HALF_W], h};
  endfunction

  function automatic logic [HALF_W-1:0] get_half(logic [WORD_W-1:0] w, logic hi);
    return hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  // first halfword is the upper lane unless the order bit is set
  assign hi_lane = ~(half_i ^ order_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      order_q <= 1'b0;
      pf_q    <= 1'b0;
      inc_q   <= 1'b0;
      rd_hi_q <= 1'b0;
      err_q   <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      latch_q <= '0;
      maddr_q <= '0;
      mwd_q   <= '0;
      hout_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (evt_i) begin
          unique case (sel_i)
            SEL_CTRL:
              if (rw_i) hout_q  <= {{(HALF_W-1){1'b0}}, order_q};
              else      order_q <= wdata_i[0];
            SEL_ADDR:
              if (rw_i) hout_q <= get_half(addr_q, hi_lane);
              else begin
                addr_q <= put_half(addr_q, hi_lane, wdata_i);
                pf_q   <= 1'b0;
              end
            default: begin
              inc_q <= (sel_i == SEL_DINC);
              if (!rw_i) begin
                latch_q <= put_half(latch_q, hi_lane, wdata_i);
                pf_q    <= 1'b0;
                if (half_i) begin
                  req_q   <= 1'b1;
                  we_q    <= 1'b1;
                  maddr_q <= addr_q;
                  mwd_q   <= put_half(latch_q, hi_lane, wdata_i);
                  st_q    <= ST_WR;
                end
              end else if (!half_i) begin
                if (pf_q) begin
                  hout_q <= get_half(latch_q, hi_lane);
                  pf_q   <= 1'b0;
                end else begin
                  req_q   <= 1'b1;
                  we_q    <= 1'b0;
                  maddr_q <= addr_q;
                  rd_hi_q <= hi_lane;
                  st_q    <= ST_RD;
                end
              end else begin
                hout_q <= get_half(latch_q, hi_lane);
                if (sel_i == SEL_DINC) begin
                  addr_q  <= addr_q + STEP;
                  maddr_q <= addr_q + STEP;
                  req_q   <= 1'b1;
                  we_q    <= 1'b0;
                  st_q    <= ST_PF;
                end
              end
            end
          endcase
        end
        ST_WR: if (mem_ack_i) begin
          we_q <= 1'b0;
          if (inc_q) begin
            addr_q  <= addr_q + STEP;
            maddr_q <= addr_q + STEP;
            st_q    <= ST_PF;
          end else begin
            req_q <= 1'b0;
            st_q  <= ST_IDLE;
          end
        end
        ST_RD: if (mem_ack_i) begin
          latch_q <= mem_rdata_i;
          hout_q  <= get_half(mem_rdata_i, rd_hi_q);
          req_q   <= 1'b0;
          st_q    <= ST_IDLE;
        end
        default: if (mem_ack_i) begin
          latch_q <= mem_rdata_i;
          pf_q    <= 1'b1;
          req_q   <= 1'b0;
          st_q    <= ST_IDLE;
        end
      endcase
      if (evt_i && st_q != ST_IDLE) err_q <= 1'b1;
    end
  end

  assign rdata_o     = hout_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign err_o       = err_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = mwd_q;
endmodule

// File: rtl/hpb_bridge.sv
module hpb_bridge
  import hpb_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        hsel_i,
  input  logic              hrw_i,
  input  logic              hhalf_i,
  input  logic              hstrb_ni,
  input  logic [WORD_W/2-1:0] hdata_i,
  output logic [WORD_W/2-1:0] hdata_o,
  output logic              hdata_oe_o,
  output logic              hnrdy_o,
  output logic              proto_err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int CW = 5;

  logic [CW-1:0] ctl_s;
  logic          strb_s, rw_s, half_s, strb_d_q, evt;

  hpb_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CW'(5'b10000))) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hstrb_ni, hrw_i, hhalf_i, hsel_i}),
    .q_o   (ctl_s)
  );

  assign strb_s = ctl_s[4];
  assign rw_s   = ctl_s[3];
  assign half_s = ctl_s[2];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) strb_d_q <= 1'b1;
    else         strb_d_q <= strb_s;

  assign evt        = strb_d_q & ~strb_s;
  assign hdata_oe_o = ~strb_s & rw_s;

  hpb_engine #(.WORD_W(WORD_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .sel_i      (hsel_e'(ctl_s[1:0])),
    .rw_i       (rw_s),
    .half_i     (half_s),
    .wdata_i    (hdata_i),
    .rdata_o    (hdata_o),
    .busy_o     (hnrdy_o),
    .err_o      (proto_err_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );
endmodule

// File: rtl/hpb_bridge_chk.sv
module hpb_bridge_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hrw_i,
  input logic              hstrb_ni,
  input logic              hdata_oe_o,
  input logic              hnrdy_o,
  input logic              proto_err_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R6

  AST_REQ_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> hnrdy_o); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R10

  AST_OE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdata_oe_o |-> ($past(hrw_i, 2) && !$past(hstrb_ni, 2))); // R9

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> !(mem_req_o && mem_we_o)); // R5
endmodule

bind hpb_bridge hpb_bridge_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hrw_i      (hrw_i),
  .hstrb_ni   (hstrb_ni),
  .hdata_oe_o (hdata_oe_o),
  .hnrdy_o    (hnrdy_o),
  .proto_err_o(proto_err_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/hpb_bridge_bench.sv
module hpb_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hsel = 2'b00;
  logic        hrw = 1'b0, hhalf = 1'b0, hstrb = 1'b1;
  logic [15:0] hdin = '0;
  logic [15:0] hdout;
  logic        hoe, nrdy, perr;
  logic        mreq, mwe, mack;
  logic [31:0] maddr, mwdata, mrdata;

  logic [31:0] mem [NWORDS];
  int          lat_cnt, mem_lat = 2, acks;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic        ord = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpb_bridge u_hpb_bridge (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .hrw_i(hrw), .hhalf_i(hhalf),
    .hstrb_ni(hstrb), .hdata_i(hdin), .hdata_o(hdout), .hdata_oe_o(hoe),
    .hnrdy_o(nrdy), .proto_err_o(perr), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_ack_i(mack), .mem_rdata_i(mrdata)
  );

  function automatic logic [31:0] init_word(int i);
    return {8'hC0 + 8'(i), 8'h11, 8'h22 ^ 8'(i), 8'h5A};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= init_word(i);
      mack <= 1'b0; mrdata <= '0; lat_cnt <= 0; acks <= 0;
    end else begin
      mack <= 1'b0;
      if (mreq && !mack) begin
        if (lat_cnt >= mem_lat) begin
          mack <= 1'b1; lat_cnt <= 0; acks <= acks + 1;
          if (mwe) mem[maddr[5:2]] <= mwdata;
          else     mrdata <= mem[maddr[5:2]];
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sel, input logic rw, input logic half,
                     input logic [15:0] din, output logic [15:0] dout, output logic oe);
    @(negedge clk); hsel = sel; hrw = rw; hhalf = half; hdin = din;
    @(negedge clk); hstrb = 1'b0;
    repeat (5) @(negedge clk);
    while (nrdy) @(negedge clk);
    dout = hdout; oe = hoe;
    @(negedge clk); hstrb = 1'b1;
    repeat (4) @(negedge clk);
    hrw = 1'b0;
  endtask

  task automatic wr32(input logic [1:0] sel, input logic [31:0] w);
    logic [15:0] d; logic oe;
    acc(sel, 1'b0, 1'b0, ord ? w[15:0] : w[31:16], d, oe);
    acc(sel, 1'b0, 1'b1, ord ? w[31:16] : w[15:0], d, oe);
  endtask

  task automatic rd32(input logic [1:0] sel, output logic [31:0] w);
    logic [15:0] a, b; logic oe;
    acc(sel, 1'b1, 1'b0, 16'h0, a, oe);
    acc(sel, 1'b1, 1'b1, 16'h0, b, oe);
    w = ord ? {b, a} : {a, b};
  endtask

  task automatic set_order(input logic o);
    logic [15:0] d; logic oe;
    acc(2'b00, 1'b0, 1'b1, {15'h7FFF, o}, d, oe);
    ord = o;
  endtask

  task automatic t_reset;
    chk("R1 not-ready", 32'(nrdy), 0);
    chk("R1 mem_req", 32'(mreq), 0);
    chk("R1 proto_err", 32'(perr), 0);
    chk("R1 oe", 32'(hoe), 0);
  endtask

  task automatic t_ctrl;
    logic [15:0] d; logic oe;
    acc(2'b00, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R1 R4 default order", 32'(d), 0);
    acc(2'b00, 1'b0, 1'b1, 16'h0001, d, oe);
    acc(2'b00, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R4 ctrl read first half", 32'(d), 1);
    acc(2'b00, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R4 ctrl read second half", 32'(d), 1);
    acc(2'b00, 1'b0, 1'b0, 16'hFFFE, d, oe);
    acc(2'b00, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R4 ctrl cleared via first half", 32'(d), 0);
  endtask

  task automatic t_addr;
    logic [15:0] d; logic oe;
    set_order(1'b1);
    wr32(2'b01, 32'h0000_0008);
    acc(2'b01, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R2 R3 addr low half first", 32'(d), 32'h0008);
    acc(2'b01, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R2 addr high half", 32'(d), 32'h0000);
  endtask

  task automatic t_write_fixed;
    logic [15:0] d; logic oe; int a0;
    a0 = acks;
    acc(2'b11, 1'b0, 1'b0, 16'h5678, d, oe);
    chk("R5 no request after first half", 32'(acks), 32'(a0));
    chk("R9 no oe on write", 32'(oe), 0);
    acc(2'b11, 1'b0, 1'b1, 16'h1234, d, oe);
    chk("R5 one write", 32'(acks), 32'(a0 + 1));
    chk("R5 R3 word written", mem[2], 32'h1234_5678);
    acc(2'b01, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R8 fixed select keeps address", 32'(d), 32'h0008);
  endtask

  task automatic t_read_fixed;
    logic [15:0] d; logic oe; int a0;
    a0 = acks;
    acc(2'b11, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R7 first half read", 32'(d), 32'h5678);
    chk("R7 fetch issued", 32'(acks), 32'(a0 + 1));
    chk("R9 oe on read", 32'(oe), 1);
    acc(2'b11, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R7 second half read", 32'(d), 32'h1234);
    chk("R7 no fetch for second half", 32'(acks), 32'(a0 + 1));
  endtask

  task automatic t_order;
    logic [15:0] d; logic oe;
    set_order(1'b0);
    wr32(2'b01, 32'h0000_000C);
    acc(2'b01, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R3 addr low half second", 32'(d), 32'h000C);
    acc(2'b11, 1'b0, 1'b0, 16'hAAAA, d, oe);
    acc(2'b11, 1'b0, 1'b1, 16'hBBBB, d, oe);
    chk("R3 upper half first on write", mem[3], 32'hAAAA_BBBB);
  endtask

  task automatic t_seq;
    logic [15:0] d; logic oe; int a0; logic [31:0] w;
    a0 = acks;
    rd32(2'b10, w);
    chk("R8 sequential read word", w, 32'hAAAA_BBBB);
    chk("R8 fetch plus prefetch", 32'(acks), 32'(a0 + 2));
    acc(2'b01, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R8 address advanced by 4", 32'(d), 32'h0010);
    acc(2'b10, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R8 prefetched first half", 32'(d), 32'(init_word(4) >> 16));
    chk("R8 no fetch after prefetch", 32'(acks), 32'(a0 + 2));
    acc(2'b10, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R8 prefetched second half", 32'(d), 32'(init_word(4) & 32'hFFFF));
    chk("R8 next prefetch", 32'(acks), 32'(a0 + 3));
    a0 = acks;
    wr32(2'b10, 32'hDEAD_BEEF);
    chk("R8 auto-increment write", mem[5], 32'hDEAD_BEEF);
    chk("R8 write then prefetch", 32'(acks), 32'(a0 + 2));
    acc(2'b01, 1'b1, 1'b1, 16'h0, d, oe);
    chk("R8 address after write", 32'(d), 32'h0018);
  endtask

  task automatic t_flush;
    logic [15:0] d; logic oe; int a0;
    wr32(2'b01, 32'h0000_0018);
    a0 = acks;
    acc(2'b11, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R11 refetch after address write", 32'(acks), 32'(a0 + 1));
    chk("R11 fetched data", 32'(d), 32'(init_word(6) >> 16));
  endtask

  task automatic t_err;
    logic [15:0] d; logic oe;
    mem_lat = 30;
    acc(2'b11, 1'b0, 1'b0, 16'h0102, d, oe);
    @(negedge clk); hsel = 2'b11; hrw = 1'b0; hhalf = 1'b1; hdin = 16'h0304;
    @(negedge clk); hstrb = 1'b0;
    repeat (8) @(negedge clk);
    chk("R6 not ready during write", 32'(nrdy), 1);
    hstrb = 1'b1;
    repeat (4) @(negedge clk);
    hsel = 2'b00; hhalf = 1'b0; hdin = 16'h0001;
    @(negedge clk); hstrb = 1'b0;
    repeat (5) @(negedge clk);
    hstrb = 1'b1;
    while (nrdy) @(negedge clk);
    repeat (4) @(negedge clk);
    mem_lat = 2;
    chk("R10 error flagged", 32'(perr), 1);
    acc(2'b00, 1'b1, 1'b0, 16'h0, d, oe);
    chk("R10 busy strobe ignored", 32'(d), 0);
    chk("R10 error sticky", 32'(perr), 1);
    chk("R5 write after busy strobe", mem[6], 32'h0102_0304);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_ctrl();
    t_addr();
    t_write_fixed();
    t_read_fixed();
    t_order();
    t_seq();
    t_flush();
    t_err();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule